// File: doc/BRIEF.md
# Timestamp Compare Unit

This block sits beside a free-running 31-bit timestamp counter and watches it with four independent output-compare channels. Each channel owns a control word and a compare word in a small register window. When the counter reaches a channel's armed target, the channel raises a sticky event flag. Depending on its mode, it also flips its output pin or emits a one-clock pulse on it. One interrupt line combines every channel whose flag is set and whose interrupt enable is on.

The compare word is double-buffered so that periodic outputs, such as a once-per-second pulse, keep running without gaps. Software arms the first target while the channel is off. It then turns the mode on and writes the following target, which waits in a queue. Each match promotes the queued target to active, and software then refills the queue with the target after that. The counter wraps across the full 31-bit range, and targets compare modulo that range.

Top module: `timer_cmp_unit`

## Requirements
- R1: After reset every control word, compare word and the shared flag word read zero, every pin is low and the interrupt is low.
- R2: Control word fields: mode in bits [5:2], interrupt enable in bit 6 and event flag in bit 7 read back as written. Bits 1:0 and 31:8 read zero.
- R3: A compare write made while the channel's mode is zero loads the active target at once, and it reads back on the compare address. A compare write made while the mode is non-zero only queues the value, and the readback keeps showing the active target.
- R4: When the counter equals the active target and the mode is non-zero, the event flag reads 1 on the next cycle. A channel whose mode is zero never sets its flag.
- R5: Writing 1 to control bit 7 clears the flag, and writing 0 there leaves it unchanged. If a match and a clearing write land in the same cycle, the flag stays set.
- R6: On a match, a queued target becomes the active one. With no value queued, the active target stays as it was.
- R7: In mode 0x5 the pin inverts on every match.
- R8: In mode 0xF the pin goes high for exactly one clock cycle after a match. Any other non-zero mode sets the flag and leaves the pin alone.
- R9: The interrupt is high exactly when some channel has both its flag and its interrupt enable set.
- R10: A control write whose mode field is zero turns the channel off. It drives the pin low, drops any queued target and blocks further matches.
- R11: Compare values are 31 bits wide. Write bit 31 is ignored and reads 0. Targets 0x7FFFFFFF and 0 match at the counter's wrap.
- R12: A match fires once per arrival of the counter at the target. A counter that stays on the target raises no further event.
- R13: Byte address 0x00 holds the shared flag word, with channel n's flag in bit n. Channel n's control word is at 0x08*(n+1) and its compare word is at 0x08*(n+1)+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 31 | Current timestamp counter value |
| addr_i | input | 8 | Register byte address, used for reads and writes |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_o | output | 4 | Per-channel compare output |
| irq_o | output | 1 | Combined channel interrupt |

## Verification
Register writes, flag updates, target promotion and pin changes all take effect at the first rising edge after the stimulus is presented. Read data follows the address with no clock. The bench applies each write or counter value at a falling edge and checks flags, pins and the interrupt at the next falling edge, so exactly one rising edge has passed. The one-cycle pulse is checked at two consecutive falling edges. Readback is sampled 1 ns after the address is set, before any edge.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int MODE_W   = 4;
  localparam int MODE_LSB = 2;
  localparam int IE_BIT   = 6;
  localparam int FLAG_BIT = 7;

  localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
  localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;
endpackage

// File: rtl/tcmp_decode.sv
module tcmp_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output logic              sel_glob_o,
  output logic [NUM_CH-1:0] sel_ctrl_o,
  output logic [NUM_CH-1:0] sel_cmp_o,
  output logic [NUM_CH-1:0] ctrl_we_o,
  output logic [NUM_CH-1:0] cmp_we_o
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             upper;
  logic             unused_lsb;

  assign idx        = addr_i[ADDR_W-1:3];
  assign upper      = addr_i[2];
  assign unused_lsb = ^addr_i[1:0];
  assign sel_glob_o = (idx == '0) && !upper;

  // slot 0 is the shared word, channel n lives in slot n+1
  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    logic hit_slot;
    assign hit_slot      = (idx == IDX_W'(c + 1));
    assign sel_ctrl_o[c] = hit_slot && !upper;
    assign sel_cmp_o[c]  = hit_slot && upper;
    assign ctrl_we_o[c]  = wr_en_i && sel_ctrl_o[c];
    assign cmp_we_o[c]   = wr_en_i && sel_cmp_o[c];
  end
endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
  import tcmp_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ctrl_we_i,
  input  logic              cmp_we_i,
  input  logic [5:0]        ctrl_wd_i,   // {flag_clr, ie, mode}
  input  logic [CNT_W-1:0]  cmp_wd_i,
  output logic [7:0]        ctrl_rd_o,
  output logic [CNT_W-1:0]  cmp_rd_o,
  output logic              flag_o,
  output logic              ie_o,
  output logic              hit_o,
  output logic              pin_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_q;
  logic              ie_q, flag_q, pin_q, eq_q;
  logic [CNT_W-1:0]  act_q, nxt_q;
  logic              nxt_vld_q;
  logic              eq, hit, turn_off, flag_clr;

  assign turn_off = ctrl_we_i && (ctrl_wd_i[MODE_W-1:0] == MODE_OFF);
  assign flag_clr = ctrl_we_i && ctrl_wd_i[5];
  assign eq       = (mode_q != MODE_OFF) && (cnt_i == act_q);
  // one event per arrival at the target
  assign hit      = eq && !eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      ie_q   <= 1'b0;
    end else if (ctrl_we_i) begin
      mode_q <= ctrl_wd_i[MODE_W-1:0];
      ie_q   <= ctrl_wd_i[4];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      eq_q <= eq;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      nxt_q     <= '0;
      nxt_vld_q <= 1'b0;
    end else begin
      if (cmp_we_i && (mode_q == MODE_OFF)) begin
        act_q     <= cmp_wd_i;
        nxt_vld_q <= 1'b0;
      end else begin
        if (hit && nxt_vld_q) begin
          act_q     <= nxt_q;
          nxt_vld_q <= 1'b0;
        end
        if (cmp_we_i) begin
          nxt_q     <= cmp_wd_i;
          nxt_vld_q <= 1'b1;
        end
      end
      if (turn_off) nxt_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (turn_off) begin
      pin_q <= 1'b0;
    end else begin
      unique case (mode_q)
        MODE_PULSE:  pin_q <= hit;
        MODE_TOGGLE: if (hit) pin_q <= !pin_q;
        default:     ;
      endcase
    end
  end

  assign ctrl_rd_o = {flag_q, ie_q, mode_q, 2'b00};
  assign cmp_rd_o  = act_q;
  assign flag_o    = flag_q;
  assign ie_o      = ie_q;
  assign hit_o     = hit;
  assign pin_o     = pin_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/timer_cmp_unit.sv
module timer_cmp_unit
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 31,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pin_o,
  output logic              irq_o
);
  localparam int DATA_W = 32;

  logic              sel_glob_w;
  logic [NUM_CH-1:0] sel_ctrl_w, sel_cmp_w, ctrl_we_w, cmp_we_w, off_we_w;
  logic [NUM_CH-1:0] flag_w, ie_w, hit_w, pulse_w, tog_w;
  logic [7:0]        ctrl_rd_w [NUM_CH];
  logic [CNT_W-1:0]  cmp_rd_w  [NUM_CH];
  logic              unused_wd;

  assign unused_wd = ^{wdata_i[DATA_W-1], wdata_i[1:0]};

  tcmp_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .sel_glob_o (sel_glob_w),
    .sel_ctrl_o (sel_ctrl_w),
    .sel_cmp_o  (sel_cmp_w),
    .ctrl_we_o  (ctrl_we_w),
    .cmp_we_o   (cmp_we_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MODE_W-1:0] mode_w;
    tcmp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt_i),
      .ctrl_we_i (ctrl_we_w[c]),
      .cmp_we_i  (cmp_we_w[c]),
      .ctrl_wd_i (wdata_i[FLAG_BIT:MODE_LSB]),
      .cmp_wd_i  (wdata_i[CNT_W-1:0]),
      .ctrl_rd_o (ctrl_rd_w[c]),
      .cmp_rd_o  (cmp_rd_w[c]),
      .flag_o    (flag_w[c]),
      .ie_o      (ie_w[c]),
      .hit_o     (hit_w[c]),
      .pin_o     (pin_o[c]),
      .mode_o    (mode_w)
    );
    assign pulse_w[c]  = (mode_w == MODE_PULSE);
    assign tog_w[c]    = (mode_w == MODE_TOGGLE);
    assign off_we_w[c] = ctrl_we_w[c] && (wdata_i[MODE_LSB+MODE_W-1:MODE_LSB] == MODE_OFF);
  end

  assign irq_o = |(flag_w & ie_w);

  always_comb begin
    rdata_o = '0;
    if (sel_glob_w) rdata_o = {{(DATA_W-NUM_CH){1'b0}}, flag_w};
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_ctrl_w[c]) rdata_o = {{(DATA_W-8){1'b0}}, ctrl_rd_w[c]};
      if (sel_cmp_w[c])  rdata_o = {{(DATA_W-CNT_W){1'b0}}, cmp_rd_w[c]};
    end
  end
endmodule

// File: rtl/timer_cmp_unit_chk.sv
module timer_cmp_unit_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] hit_i,
  input logic [NUM_CH-1:0] flag_i,
  input logic [NUM_CH-1:0] pin_i,
  input logic [NUM_CH-1:0] pulse_i,
  input logic [NUM_CH-1:0] tog_i,
  input logic [NUM_CH-1:0] ctrl_we_i,
  input logic [NUM_CH-1:0] off_we_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r4_hit_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[c] |=> flag_i[c]);
    a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_i[c] && !ctrl_we_i[c] |=> flag_i[c]);
    a_r7_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tog_i[c] && hit_i[c] && !ctrl_we_i[c] |=> pin_i[c] != $past(pin_i[c]));
    a_r8_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_i[c] && pin_i[c] && !hit_i[c] && !ctrl_we_i[c] |=> !pin_i[c]);
    a_r10_off_drops_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_we_i[c] |=> !pin_i[c]);
  end
endmodule

bind timer_cmp_unit timer_cmp_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hit_i     (hit_w),
  .flag_i    (flag_w),
  .pin_i     (pin_o),
  .pulse_i   (pulse_w),
  .tog_i     (tog_w),
  .ctrl_we_i (ctrl_we_w),
  .off_we_i  (off_we_w)
);

// File: tb/timer_cmp_unit_bench.sv
module timer_cmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] cnt = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pin;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timer_cmp_unit u_timer_cmp_unit (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin), .irq_o(irq)
  );

  function automatic logic [7:0] a_ctrl(int c); return 8'(8 * (c + 1)); endfunction
  function automatic logic [7:0] a_cmp(int c);  return 8'(8 * (c + 1) + 4); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(input logic [30:0] v);
    @(negedge clk); cnt = v;
    @(negedge clk);
  endtask

  // mode, ie, target, counter, expected flag, expected pin
  localparam int NV = 8;
  localparam logic [3:0]  T_MODE [NV] = '{4'h5, 4'h5, 4'hF, 4'hF, 4'h0, 4'h3, 4'h5, 4'hF};
  localparam logic        T_IE   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [30:0] T_CMP  [NV] = '{31'd100, 31'd100, 31'h7FFFFFFF, 31'd0,
                                         31'd55, 31'd7, 31'h12345678, 31'd9};
  localparam logic [30:0] T_CNT  [NV] = '{31'd100, 31'd101, 31'h7FFFFFFF, 31'd0,
                                         31'd55, 31'd7, 31'h12345678, 31'd8};
  localparam logic        T_FLAG [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic        T_PIN  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(a_ctrl(c), d); chk("R1 ctrl reset", d, 32'h0);
      rd(a_cmp(c), d);  chk("R1 cmp reset", d, 32'h0);
    end
    rd(8'h00, d); chk("R1 flags reset", d, 32'h0);
    chk("R1 pins reset", {28'h0, pin}, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);

    // table walk on channel 0: R4 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      step(~T_CNT[i]);
      wr(a_ctrl(0), 32'h80);
      wr(a_cmp(0), {1'b0, T_CMP[i]});
      wr(a_ctrl(0), {25'h0, T_IE[i], T_MODE[i], 2'b00});
      step(T_CNT[i]);
      rd(a_ctrl(0), d);
      chk($sformatf("R4 row%0d ctrl", i), d, {24'h0, T_FLAG[i], T_IE[i], T_MODE[i], 2'b00});
      chk($sformatf("R7/R8 row%0d pin", i), {31'h0, pin[0]}, {31'h0, T_PIN[i]});
      chk($sformatf("R9 row%0d irq", i), {31'h0, irq}, {31'h0, T_FLAG[i] & T_IE[i]});
      if (T_MODE[i] == 4'hF && T_FLAG[i]) begin
        @(negedge clk);
        chk($sformatf("R8 row%0d pulse ends", i), {31'h0, pin[0]}, 32'h0);
      end
    end

    // R2 field readback
    wr(a_ctrl(2), 32'hFFFFFF7F);
    rd(a_ctrl(2), d); chk("R2 fields", d, 32'h7C);
    wr(a_ctrl(2), 32'h80);
    // R11 31-bit compare
    wr(a_cmp(2), 32'hFFFFFFFF);
    rd(a_cmp(2), d); chk("R11 bit31 dropped", d, 32'h7FFFFFFF);

    // R3 R6 R7 double buffer on channel 1
    step(31'd5);
    wr(a_ctrl(1), 32'h80);
    wr(a_cmp(1), 32'd1000);
    rd(a_cmp(1), d); chk("R3 direct load", d, 32'd1000);
    wr(a_ctrl(1), 32'h14);
    wr(a_cmp(1), 32'd2000);
    rd(a_cmp(1), d); chk("R3 queued write", d, 32'd1000);
    step(31'd1000);
    chk("R7 toggle high", {31'h0, pin[1]}, 32'h1);
    rd(a_cmp(1), d); chk("R6 promote", d, 32'd2000);
    rd(a_ctrl(1), d); chk("R4 flag ch1", d, 32'h94);
    step(31'd2000);
    chk("R7 toggle low", {31'h0, pin[1]}, 32'h0);
    rd(a_cmp(1), d); chk("R6 no queue", d, 32'd2000);

    // R5 clear, R12 held counter
    wr(a_ctrl(1), 32'h94);
    repeat (3) @(negedge clk);
    rd(a_ctrl(1), d); chk("R12 held counter no refire", d, 32'h14);
    chk("R12 pin stays", {31'h0, pin[1]}, 32'h0);
    step(31'd2001);
    step(31'd2000);
    chk("R12 rearrival fires", {31'h0, pin[1]}, 32'h1);
    wr(a_ctrl(1), 32'h14);
    rd(a_ctrl(1), d); chk("R5 write zero keeps flag", d, 32'h94);
    chk("R9 ie off no irq", {31'h0, irq}, 32'h0);

    // R5 set wins over same-cycle clear
    wr(a_cmp(1), 32'd3000);
    step(31'd2001);
    @(negedge clk); cnt = 31'd2000; addr = a_ctrl(1); wdata = 32'h94; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(a_ctrl(1), d); chk("R5 set wins", d, 32'h94);
    rd(a_cmp(1), d); chk("R6 promote second", d, 32'd3000);

    // R9 R8 R13 on channel 3
    wr(a_cmp(3), 32'd50);
    wr(a_ctrl(3), 32'h7C);
    step(31'd50);
    chk("R9 irq raised", {31'h0, irq}, 32'h1);
    chk("R8 pulse high", {31'h0, pin[3]}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'h0, pin[3]}, 32'h0);
    rd(8'h00, d); chk("R13 shared flags", d, 32'hA);
    wr(a_ctrl(3), 32'hFC);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);
    rd(8'h00, d); chk("R13 shared after clear", d, 32'h2);

    // R10 disable
    step(31'd3000);
    chk("R10 pre pin high", {31'h0, pin[1]}, 32'h1);
    wr(a_ctrl(1), 32'h00);
    chk("R10 pin low", {31'h0, pin[1]}, 32'h0);
    rd(a_ctrl(1), d); chk("R10 ctrl off", d, 32'h80);
    step(31'd2999);
    step(31'd3000);
    chk("R10 no match pin", {31'h0, pin[1]}, 32'h0);
    wr(a_ctrl(1), 32'h80);
    step(31'd2999);
    step(31'd3000);
    rd(a_ctrl(1), d); chk("R10 no match flag", d, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule